// File: doc/BRIEF.md
# Counted DMA Override Unit

This block sits beside the DMA instruction decoder of a small processor core. A one-byte override command changes how the next few DMA-related instructions are routed. The top three bits of the byte select an override type. The low five bits give the number of DMA instructions the override lasts for. Each data-store, data-load or DMA-wait instruction that arrives while the override is active is tagged with a routing selection, and it uses up one count. When the count runs out, instructions go back to the normal route.

Under type 0, a transfer moves between local data memory and a crypto register. The instruction's length field is then read as the index of that register. Under type 1, external memory is steered to the crypto engine's input/output stream. The other type codes are accepted, latched and counted, and they carry a reserved routing code. The crypto datapath itself is outside this block.

Every instruction strobe comes out one cycle later from registered outputs. The routing selection and the register index come out in the same cycle as the strobe they belong to.

Top module: `dma_ovr_unit`

## Requirements
- R1: After synchronous reset, `out_valid` is 0, `out_route` is 0, `out_creg_idx` is 0, and no override is active, so the first DMA instruction takes the normal route (code 0).
- R2: The command byte carries the type in bits [7:5] and the count in bits [4:0]. Any count from 1 to 31 makes exactly that many DMA instructions rerouted.
- R3: Under type 0, every DMA instruction (kind 1 store, 2 load, 3 wait) gets route code 1, meaning data memory to or from a crypto register.
- R4: Under type 0, a store or load sets `out_creg_idx` to the low IDX_W bits of `instr_len`. A wait sets it to 0.
- R5: Under type 1, DMA instructions get route code 2 (crypto stream) and `out_creg_idx` 0.
- R6: Types 2 to 7 are latched and consume count like the others. DMA instructions under them get route code 3 (reserved).
- R7: Each DMA instruction consumes one count. Once the count reaches zero, DMA instructions get route code 0.
- R8: A command with count 0 applies no override. The next DMA instruction gets route code 0.
- R9: A non-DMA instruction (kind 0) is passed through with route code 0 and does not consume count.
- R10: A new command replaces any override that is still active and reloads both type and count.
- R11: Timing. `out_valid`, `out_kind` and `out_len` are the values of `instr_valid`, `instr_kind` and `instr_len` from one cycle earlier. When `out_valid` is 0, route and index are 0. An instruction that arrives in the same cycle as a command is routed by the state that held before the command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Override command strobe |
| cmd_byte | input | 3+CNT_W | Type in the top 3 bits, count in the low CNT_W bits |
| instr_valid | input | 1 | Instruction strobe |
| instr_kind | input | 2 | 0 other, 1 store, 2 load, 3 wait |
| instr_len | input | LEN_W | Length field of the instruction |
| out_valid | output | 1 | Registered instruction strobe |
| out_kind | output | 2 | Registered instruction kind |
| out_len | output | LEN_W | Registered length field |
| out_route | output | 2 | 0 normal, 1 crypto register, 2 crypto stream, 3 reserved |
| out_creg_idx | output | IDX_W | Crypto register index under type 0 |

## Verification
The bench runs a count of 31 to its last instruction and checks that the 32nd is normal. A design that was off by one in the decrement would reroute one instruction too many or too few. It mixes kind-0 instructions into an active override, which catches a design that lets them consume count. It also issues a command in the same cycle as an instruction, to catch a design that routes that instruction by the new command instead of the state before it. Count-0 and reserved-type commands are included too: a design that treated count 0 as active, or dropped reserved types, would produce a wrong route code.

// File: rtl/dma_ovr_pkg.sv
package dma_ovr_pkg;
  localparam int TYPE_W = 3;

  localparam logic [1:0] KIND_OTHER = 2'd0;
  localparam logic [1:0] KIND_STORE = 2'd1;
  localparam logic [1:0] KIND_LOAD  = 2'd2;
  localparam logic [1:0] KIND_WAIT  = 2'd3;

  localparam logic [1:0] ROUTE_NORMAL = 2'd0;
  localparam logic [1:0] ROUTE_CREG   = 2'd1;
  localparam logic [1:0] ROUTE_STREAM = 2'd2;
  localparam logic [1:0] ROUTE_RSVD   = 2'd3;

  localparam logic [TYPE_W-1:0] OVR_CREG   = 3'd0;
  localparam logic [TYPE_W-1:0] OVR_STREAM = 3'd1;
endpackage

// File: rtl/dma_ovr_latch.sv
module dma_ovr_latch
  import dma_ovr_pkg::*;
#(
  parameter int CNT_W = 5,
  localparam int CMD_W = TYPE_W + CNT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [CMD_W-1:0]  cmd_byte,
  input  logic              dma_strobe,
  output logic [TYPE_W-1:0] ovr_type,
  output logic              ovr_active
);
  logic [CNT_W-1:0] remain_q;

  assign ovr_active = (remain_q != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      remain_q <= '0;
      ovr_type <= '0;
    end else if (cmd_valid) begin
      ovr_type <= cmd_byte[CMD_W-1 -: TYPE_W];
      remain_q <= cmd_byte[CNT_W-1:0];
    end else if (dma_strobe && ovr_active) begin
      remain_q <= remain_q - 1'b1;
    end
  end
endmodule

// File: rtl/dma_ovr_route.sv
module dma_ovr_route
  import dma_ovr_pkg::*;
#(
  parameter int LEN_W = 16,
  parameter int IDX_W = 3
) (
  input  logic              ovr_active,
  input  logic [TYPE_W-1:0] ovr_type,
  input  logic [1:0]        kind,
  input  logic [LEN_W-1:0]  len,
  output logic [1:0]        route,
  output logic [IDX_W-1:0]  creg_idx
);
  always_comb begin
    route    = ROUTE_NORMAL;
    creg_idx = '0;
    if (ovr_active && kind != KIND_OTHER) begin
      unique case (ovr_type)
        OVR_CREG: begin
          route = ROUTE_CREG;
          if (kind != KIND_WAIT) creg_idx = len[IDX_W-1:0];
        end
        OVR_STREAM: route = ROUTE_STREAM;
        default:    route = ROUTE_RSVD;
      endcase
    end
  end
endmodule

// File: rtl/dma_ovr_unit.sv
module dma_ovr_unit
  import dma_ovr_pkg::*;
#(
  parameter int CNT_W = 5,
  parameter int LEN_W = 16,
  parameter int IDX_W = 3,
  localparam int CMD_W = TYPE_W + CNT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  input  logic [CMD_W-1:0] cmd_byte,
  input  logic             instr_valid,
  input  logic [1:0]       instr_kind,
  input  logic [LEN_W-1:0] instr_len,
  output logic             out_valid,
  output logic [1:0]       out_kind,
  output logic [LEN_W-1:0] out_len,
  output logic [1:0]       out_route,
  output logic [IDX_W-1:0] out_creg_idx
);
  logic [TYPE_W-1:0] ovr_type;
  logic              ovr_active;
  logic              dma_strobe;
  logic [1:0]        route_c;
  logic [IDX_W-1:0]  idx_c;

  assign dma_strobe = instr_valid && (instr_kind != KIND_OTHER);

  dma_ovr_latch #(.CNT_W(CNT_W)) latch_i (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
    .dma_strobe(dma_strobe), .ovr_type(ovr_type), .ovr_active(ovr_active)
  );

  dma_ovr_route #(.LEN_W(LEN_W), .IDX_W(IDX_W)) route_i (
    .ovr_active(ovr_active), .ovr_type(ovr_type), .kind(instr_kind),
    .len(instr_len), .route(route_c), .creg_idx(idx_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid    <= 1'b0;
      out_kind     <= KIND_OTHER;
      out_len      <= '0;
      out_route    <= ROUTE_NORMAL;
      out_creg_idx <= '0;
    end else begin
      out_valid    <= instr_valid;
      out_kind     <= instr_kind;
      out_len      <= instr_len;
      out_route    <= instr_valid ? route_c : ROUTE_NORMAL;
      out_creg_idx <= instr_valid ? idx_c : '0;
    end
  end
endmodule

// File: rtl/dma_ovr_checker.sv
module dma_ovr_checker #(
  parameter int CNT_W = 5,
  parameter int LEN_W = 16,
  parameter int IDX_W = 3,
  localparam int CMD_W = 3 + CNT_W
) (
  input logic             clk,
  input logic             rst,
  input logic             cmd_valid,
  input logic [CMD_W-1:0] cmd_byte,
  input logic             instr_valid,
  input logic [1:0]       instr_kind,
  input logic [LEN_W-1:0] instr_len,
  input logic             out_valid,
  input logic [1:0]       out_route,
  input logic [IDX_W-1:0] out_creg_idx
);
  a_r11_strobe_delay: assert property (@(posedge clk) disable iff (rst)
    instr_valid |=> out_valid);
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !instr_valid |=> (!out_valid && out_route == 2'd0 && out_creg_idx == '0));
  a_r9_other_normal: assert property (@(posedge clk) disable iff (rst)
    (instr_valid && instr_kind == 2'd0) |=> out_route == 2'd0);
  a_r8_zero_count: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_byte[CNT_W-1:0] == '0) ##1 (instr_valid && !cmd_valid)
    |=> out_route == 2'd0);
  a_r4_creg_index: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_byte[CMD_W-1 -: 3] == 3'd0 && cmd_byte[CNT_W-1:0] != '0)
    ##1 (instr_valid && !cmd_valid && instr_kind == 2'd1)
    |=> (out_route == 2'd1 && out_creg_idx == $past(instr_len[IDX_W-1:0])));
  a_r5_stream: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_byte[CMD_W-1 -: 3] == 3'd1 && cmd_byte[CNT_W-1:0] != '0)
    ##1 (instr_valid && !cmd_valid && instr_kind != 2'd0)
    |=> (out_route == 2'd2 && out_creg_idx == '0));
endmodule

bind dma_ovr_unit dma_ovr_checker #(.CNT_W(CNT_W), .LEN_W(LEN_W), .IDX_W(IDX_W)) chk_i (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
  .instr_valid(instr_valid), .instr_kind(instr_kind), .instr_len(instr_len),
  .out_valid(out_valid), .out_route(out_route), .out_creg_idx(out_creg_idx)
);

// File: tb/dma_ovr_unit_tb.sv
module dma_ovr_unit_tb_top;
  localparam int CNT_W = 5;
  localparam int LEN_W = 16;
  localparam int IDX_W = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_valid = 1'b0;
  logic [7:0] cmd_byte = '0;
  logic instr_valid = 1'b0;
  logic [1:0] instr_kind = '0;
  logic [LEN_W-1:0] instr_len = '0;
  logic out_valid;
  logic [1:0] out_kind;
  logic [LEN_W-1:0] out_len;
  logic [1:0] out_route;
  logic [IDX_W-1:0] out_creg_idx;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dma_ovr_unit #(.CNT_W(CNT_W), .LEN_W(LEN_W), .IDX_W(IDX_W)) dut_i (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
    .instr_valid(instr_valid), .instr_kind(instr_kind), .instr_len(instr_len),
    .out_valid(out_valid), .out_kind(out_kind), .out_len(out_len),
    .out_route(out_route), .out_creg_idx(out_creg_idx)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic send_cmd(input logic [2:0] t, input logic [4:0] n);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_byte = {t, n};
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  // drive one instruction, then check outputs at the next falling edge
  task automatic instr(input string tag, input logic [1:0] k, input logic [LEN_W-1:0] l,
                       input int exp_route, input int exp_idx);
    @(negedge clk);
    instr_valid = 1'b1; instr_kind = k; instr_len = l;
    @(negedge clk);
    instr_valid = 1'b0; instr_kind = '0; instr_len = '0;
    chk({tag, " valid"}, out_valid, 1);
    chk({tag, " route"}, out_route, exp_route);
    chk({tag, " idx"}, out_creg_idx, exp_idx);
  endtask

  task automatic t_reset();
    chk("R1 reset valid", out_valid, 0);
    chk("R1 reset route", out_route, 0);
    chk("R1 reset idx", out_creg_idx, 0);
    instr("R1 first store normal", 2'd1, 16'h5, 0, 0);
  endtask

  task automatic t_type0();
    send_cmd(3'd0, 5'd3);
    instr("R3 R4 store idx", 2'd1, 16'h0005, 1, 5);
    instr("R4 load idx", 2'd2, 16'h001A, 1, 2);
    instr("R3 R4 wait idx0", 2'd3, 16'h0007, 1, 0);
    instr("R7 expired", 2'd1, 16'h0005, 0, 0);
  endtask

  task automatic t_type1();
    send_cmd(3'd1, 5'd2);
    instr("R5 store stream", 2'd1, 16'h0006, 2, 0);
    instr("R9 other passes", 2'd0, 16'h0006, 0, 0);
    instr("R5 R9 wait stream", 2'd3, 16'h0001, 2, 0);
    instr("R7 load normal", 2'd2, 16'h0001, 0, 0);
    @(negedge clk);
    chk("R11 idle valid", out_valid, 0);
  endtask

  task automatic t_count0();
    send_cmd(3'd0, 5'd0);
    instr("R8 count0 normal", 2'd1, 16'h0003, 0, 0);
  endtask

  task automatic t_reserved();
    send_cmd(3'd5, 5'd1);
    instr("R6 reserved route", 2'd2, 16'h0004, 3, 0);
    instr("R6 reserved consumed", 2'd2, 16'h0004, 0, 0);
  endtask

  task automatic t_replace();
    send_cmd(3'd0, 5'd5);
    instr("R10 first type", 2'd1, 16'h0001, 1, 1);
    send_cmd(3'd1, 5'd1);
    instr("R10 replaced type", 2'd1, 16'h0001, 2, 0);
    instr("R10 reloaded count", 2'd1, 16'h0001, 0, 0);
  endtask

  task automatic t_same_cycle();
    send_cmd(3'd1, 5'd1);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_byte = {3'd0, 5'd2};
    instr_valid = 1'b1; instr_kind = 2'd1; instr_len = 16'h0004;
    @(negedge clk);
    cmd_valid = 1'b0; instr_valid = 1'b0; instr_kind = '0; instr_len = '0;
    chk("R11 same-cycle old route", out_route, 2);
    chk("R11 kind copy", out_kind, 1);
    chk("R11 len copy", out_len, 4);
    instr("R11 new cmd 1", 2'd1, 16'h0006, 1, 6);
    instr("R11 new cmd 2", 2'd2, 16'h0003, 1, 3);
    instr("R11 new cmd done", 2'd1, 16'h0003, 0, 0);
  endtask

  task automatic t_max();
    send_cmd(3'd0, 5'd31);
    for (int i = 0; i < 31; i++) instr("R2 R7 max count", 2'd3, 16'h0000, 1, 0);
    instr("R2 R7 after 31", 2'd3, 16'h0000, 0, 0);
    @(negedge clk);
    instr_valid = 1'b1; instr_kind = 2'd2; instr_len = 16'hBEEF;
    @(negedge clk);
    instr_valid = 1'b0;
    chk("R11 len passthrough", out_len, 16'hBEEF);
    chk("R11 kind passthrough", out_kind, 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_type0();
    t_type1();
    t_count0();
    t_reserved();
    t_replace();
    t_same_cycle();
    t_max();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule